// File: doc/BRIEF.md
# Instruction Address Generator

This block owns the program counter of a five-step processor and works out the address of the next instruction. On each fetch it advances the counter by one instruction word. In the execute step it can add a signed displacement for a branch, either always or only when the two compared source operands are equal. For a register-indirect subroutine call it loads the counter from the first source operand.

A second register keeps a copy of the counter at the moment of a call. That copy is presented on its own output so the writeback path can store it as the return address. The control sequencer drives a two-bit next-address code, a counter write enable, a save-copy enable, the displacement, the first operand value and the equality flag. It reads back the current counter and the saved return address.

Top module: `pcgen_top`

## Requirements
- R1: While the asynchronous active-low reset is low, both the counter output and the return-address output are 0.
- R2: When the counter write enable is 0, the counter keeps its value on the next clock edge, whatever the next-address code, flag, displacement and operand are.
- R3: With the write enable at 1 and code 2'b00 (advance), the counter becomes its old value plus 4 on the next edge. It wraps modulo 2^32, so 0xFFFFFFFC advances to 0.
- R4: With the write enable at 1 and code 2'b01 (jump), the counter becomes its old value plus the displacement.
- R5: With the write enable at 1 and code 2'b10 (conditional jump), the counter becomes its old value plus the displacement when the equality flag is 1. It keeps its value when the flag is 0.
- R6: With the write enable at 1 and code 2'b11 (indirect), the counter takes the operand value on the next edge.
- R7: When the save enable is 1, the return-address output takes the counter value from before the edge, even if the counter changes on the same edge. When the save enable is 0, it holds its value.
- R8: The displacement is a 16-bit two's-complement value, sign-extended to 32 bits, so a negative displacement moves the counter backwards. The addition wraps modulo 2^32.
- R9: The equality flag has no effect under codes 2'b00, 2'b01 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pcSel | input | 2 | Next-address code: 00 advance, 01 jump, 10 conditional jump, 11 indirect |
| pcWe | input | 1 | Counter write enable |
| tempWe | input | 1 | Save current counter into the return-address register |
| brOffset | input | 16 | Signed displacement |
| raVal | input | 32 | First source operand value |
| brCond | input | 1 | Operand equality flag |
| pcOut | output | 32 | Current counter |
| retAddr | output | 32 | Saved return address |

## Verification
Random sequences mix all four codes with the write enable, save enable, flag, displacement and operand all varied independently. This separates the adder source chosen by each code from the effect of the enable, and it shows whether the flag leaks into codes that should ignore it. Directed cases cover the most negative and most positive displacements, wraparound of the advance past 0xFFFFFFFC, and a call that loads the counter and saves it on the same edge. That last case tells a pre-edge snapshot apart from a post-edge one. A not-taken conditional jump and a disabled write under every code confirm the counter really holds.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;
  typedef enum logic [1:0] {
    SEL_INC = 2'b00,
    SEL_BR  = 2'b01,
    SEL_BRC = 2'b10,
    SEL_REG = 2'b11
  } pcSel_e;

  typedef enum logic [1:0] {
    SRC_INC = 2'b00,
    SRC_OFF = 2'b01,
    SRC_REG = 2'b10
  } pcSrc_e;

  typedef struct packed {
    logic   pcLoad;
    pcSrc_e src;
    logic   tempLoad;
  } strobe_t;
endpackage

// File: rtl/pcgen_ctrl.sv
module pcgen_ctrl
  import pcgen_pkg::*;
(
  input  logic [1:0] pcSel,
  input  logic       pcWe,
  input  logic       tempWe,
  input  logic       brCond,
  output strobe_t    strobe
);
  pcSel_e selE;
  assign selE = pcSel_e'(pcSel);

  always_comb begin
    strobe.tempLoad = tempWe;
    strobe.pcLoad   = pcWe;
    strobe.src      = SRC_INC;
    unique case (selE)
      SEL_INC: strobe.src = SRC_INC;
      SEL_BR:  strobe.src = SRC_OFF;
      SEL_BRC: begin
        strobe.src    = SRC_OFF;
        strobe.pcLoad = pcWe & brCond;
      end
      SEL_REG: strobe.src = SRC_REG;
      default: strobe.src = SRC_INC;
    endcase
  end
endmodule

// File: rtl/pcgen_dp.sv
module pcgen_dp
  import pcgen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [ADDR_W-1:0] raVal,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] retAddr
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] pcQ, tempQ, offExt, nextPc;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offExt = {{EXT_W{brOffset[OFF_W-1]}}, brOffset};
    end else begin : g_noext
      assign offExt = brOffset[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (strobe.src)
      SRC_INC: nextPc = pcQ + ADDR_W'(STEP);
      SRC_OFF: nextPc = pcQ + offExt;
      SRC_REG: nextPc = raVal;
      default: nextPc = pcQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ   <= '0;
      tempQ <= '0;
    end else begin
      if (strobe.pcLoad)   pcQ   <= nextPc;
      if (strobe.tempLoad) tempQ <= pcQ;
    end
  end

  assign pcOut   = pcQ;
  assign retAddr = tempQ;
endmodule

// File: rtl/pcgen_top.sv
module pcgen_top
  import pcgen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pcSel,
  input  logic              pcWe,
  input  logic              tempWe,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [ADDR_W-1:0] raVal,
  input  logic              brCond,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] retAddr
);
  strobe_t strobe;

  pcgen_ctrl ctrl_i (
    .pcSel (pcSel),
    .pcWe  (pcWe),
    .tempWe(tempWe),
    .brCond(brCond),
    .strobe(strobe)
  );

  pcgen_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP(STEP)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .brOffset(brOffset),
    .raVal   (raVal),
    .pcOut   (pcOut),
    .retAddr (retAddr)
  );
endmodule

// File: rtl/pcgen_chk.sv
module pcgen_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        pcSel,
  input logic              pcWe,
  input logic              tempWe,
  input logic [OFF_W-1:0]  brOffset,
  input logic [ADDR_W-1:0] raVal,
  input logic              brCond,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] retAddr
);
  logic [ADDR_W-1:0] offExt;
  assign offExt = ADDR_W'($signed(brOffset));

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_r1: assert (pcOut == '0 && retAddr == '0);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pcWe |=> $stable(pcOut));

  p_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pcWe && pcSel == 2'b00) |=> pcOut == $past(pcOut) + ADDR_W'(STEP));

  p_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pcWe && pcSel == 2'b01) |=> pcOut == $past(pcOut) + $past(offExt));

  p_taken_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pcWe && pcSel == 2'b10 && brCond) |=> pcOut == $past(pcOut) + $past(offExt));

  p_nottaken_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pcWe && pcSel == 2'b10 && !brCond) |=> $stable(pcOut));

  p_indirect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pcWe && pcSel == 2'b11) |=> pcOut == $past(raVal));

  p_save_r7: assert property (@(posedge clk) disable iff (!rstN)
    tempWe |=> retAddr == $past(pcOut));

  p_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    !tempWe |=> $stable(retAddr));
endmodule

bind pcgen_top pcgen_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP(STEP)) chk_i (
  .clk(clk), .rstN(rstN), .pcSel(pcSel), .pcWe(pcWe), .tempWe(tempWe),
  .brOffset(brOffset), .raVal(raVal), .brCond(brCond),
  .pcOut(pcOut), .retAddr(retAddr)
);

// File: tb/pcgen_tb.sv
module pcgen_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pcSel = 2'b00;
  logic        pcWe = 1'b0;
  logic        tempWe = 1'b0;
  logic [15:0] brOffset = '0;
  logic [31:0] raVal = '0;
  logic        brCond = 1'b0;
  logic [31:0] pcOut, retAddr;

  int checks = 0;
  int errors = 0;
  logic [31:0] mPc = '0;
  logic [31:0] mTemp = '0;

  always #(CLK_P/2) clk = ~clk;

  pcgen_top dut_i (
    .clk(clk), .rstN(rstN), .pcSel(pcSel), .pcWe(pcWe), .tempWe(tempWe),
    .brOffset(brOffset), .raVal(raVal), .brCond(brCond),
    .pcOut(pcOut), .retAddr(retAddr)
  );

  function automatic logic [31:0] expPc(logic [31:0] pc, logic [1:0] sel, logic we,
                                        logic [15:0] off, logic [31:0] ra, logic cond);
    logic [31:0] ext;
    ext = {{16{off[15]}}, off};
    if (!we) return pc;
    case (sel)
      2'b00:   return pc + 32'd4;
      2'b01:   return pc + ext;
      2'b10:   return cond ? pc + ext : pc;
      default: return ra;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, compare at the next negedge.
  task automatic step(string tag, logic [1:0] sel, logic we, logic tw,
                      logic [15:0] off, logic [31:0] ra, logic cond);
    logic [31:0] nPc, nTemp;
    pcSel = sel; pcWe = we; tempWe = tw; brOffset = off; raVal = ra; brCond = cond;
    nPc   = expPc(mPc, sel, we, off, ra, cond);
    nTemp = tw ? mPc : mTemp;
    @(negedge clk);
    mPc = nPc; mTemp = nTemp;
    check({tag, " pc"}, pcOut, mPc);
    check({tag, " ret"}, retAddr, mTemp);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    check("R1 pc", pcOut, 32'd0);
    check("R1 ret", retAddr, 32'd0);
    rstN = 1'b1;

    step("R3 inc", 2'b00, 1, 0, 16'h1234, 32'hDEAD0000, 1);
    step("R3 inc", 2'b00, 1, 0, 16'h0, 32'h0, 0);
    step("R4 jump pos", 2'b01, 1, 0, 16'h7FFC, 32'h0, 0);
    step("R8 jump neg", 2'b01, 1, 0, 16'hFFF0, 32'h0, 1);
    step("R8 most neg", 2'b01, 1, 0, 16'h8000, 32'h0, 0);
    step("R5 taken", 2'b10, 1, 0, 16'h0100, 32'h0, 1);
    step("R5 not taken", 2'b10, 1, 0, 16'h0100, 32'h0, 0);
    for (int s = 0; s < 4; s++)
      step("R2 hold", 2'(s), 0, 0, 16'h4444, 32'h55555555, 1);
    step("R6 R7 call", 2'b11, 1, 1, 16'h0, 32'h00400000, 0);
    step("R7 keep", 2'b00, 1, 0, 16'h0, 32'h0, 0);
    step("R9 jump cond0", 2'b01, 1, 0, 16'h0010, 32'h0, 0);
    step("R9 reg cond1", 2'b11, 1, 0, 16'h0010, 32'hFFFFFFFC, 1);
    step("R3 wrap", 2'b00, 1, 0, 16'h0, 32'h0, 0);
    step("R8 neg wrap", 2'b01, 1, 0, 16'hFFFC, 32'h0, 0);
    step("R7 save no pc", 2'b00, 0, 1, 16'h0, 32'h0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [1:0]  sel;
      logic        we, tw, cond;
      logic [15:0] off;
      logic [31:0] ra;
      sel  = 2'($urandom);
      we   = ($urandom % 4) != 0;
      tw   = ($urandom % 3) == 0;
      cond = 1'($urandom);
      off  = 16'($urandom);
      ra   = $urandom;
      step("R2 R3 R4 R5 R6 R7 R9 random", sel, we, tw, off, ra, cond);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule